// File: doc/BRIEF.md
# I2C bit-clock timing generator with standard and high-speed phases

This block derives the SCL timing of an I2C master from the system clock. A predivider first divides the clock by a programmable divisor D. Two nested counters then set the length of each SCL half-period: a step counter that counts predivided ticks, and a sample counter that counts completed step periods. One half-period lasts D·S·T system cycles, where S is the sample count and T is the step count. The bus rate is therefore clk / (2·D·S·T).

The bit-level engine raises `run` for the length of a transaction. In the first cycle of `run` the block captures two words: a standard/fast timing word and a high-speed timing word. It then toggles `scl_o` at every half-period boundary and marks each boundary with `half_tick_o`. Once in every high half it gives a one-cycle `sample_stb_o` at the midpoint, where the engine samples SDA.

If the high-speed word is enabled, the transaction opens in a master-code phase that uses the standard word. Software must program that word for no more than 400 kHz. When the engine pulses `mcode_done`, the block restarts its counters with the high-speed word and keeps the current SCL level. The timing values themselves are computed by software and are outside this block.

Top module: `ssg_scl_timing`

## Requirements
- R1: After reset, and in every cycle while `run` is low, `scl_o` is 1 and `half_tick_o`, `sample_stb_o` and `hs_active_o` are 0. Changes to `div_m1`, `std_word` or `hs_word` while idle have no effect on these outputs.
- R2: The predivider divides by D = `div_m1` + 1, so `div_m1` = 4 gives the usual divide-by-5. Each step-counter advance takes exactly D clock cycles.
- R3: In the standard word, bits [10:8] hold S−1 and bits [5:0] hold T−1, so S runs 1..8 and T runs 1..64. All other bits of the word are ignored. A transaction begins with SCL high, and every half-period lasts D·S·T cycles.
- R4: `half_tick_o` is a one-cycle pulse in the first cycle of each new SCL level that a completed half-period produces. It does not pulse at transaction start or at the phase switch.
- R5: In every high half-period, `sample_stb_o` pulses for exactly one cycle, at cycle D·floor(S·T/2), where the half's first cycle is cycle 0. It never pulses during a low half-period.
- R6: The high-speed word is enabled only when its bits [1:0] equal 2'b11. Its bits [14:12] hold S−1 and bits [10:8] hold T−1, so T is at most 8. When the word is not enabled, the whole transaction uses the standard word and `hs_active_o` stays 0.
- R7: When high-speed mode is enabled, the transaction starts with the standard word. A `mcode_done` pulse in cycle k restarts the predivider and both counters from cycle k+1 and keeps the SCL level. From then on every half-period lasts D·S'·T' cycles, using the high-speed counts, and `hs_active_o` is 1.
- R8: `mcode_done` is ignored outside the master-code phase: when high-speed mode is disabled, and after the switch has already happened.
- R9: `div_m1` and both timing words are captured only in the first cycle of `run` after it was low. Changes to them during a transaction have no effect, and the next transaction uses the new values.
- R10: One cycle after `run` falls, the block is idle (SCL high, `hs_active_o` 0, no pulses). The next rise of `run` starts a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High for the length of a transaction |
| mcode_done | input | 1 | One-cycle pulse: master code sent, switch to high-speed timing |
| div_m1 | input | DIV_W | Predivider divisor minus one |
| std_word | input | 16 | Standard/fast timing word |
| hs_word | input | 16 | High-speed timing word |
| scl_o | output | 1 | SCL level to the bit engine |
| half_tick_o | output | 1 | First cycle of a new SCL level |
| sample_stb_o | output | 1 | SDA sample strobe at the middle of each high half |
| hs_active_o | output | 1 | High-speed timing in use |

## Verification
All outputs are registered, so each change becomes visible one cycle after the edge that caused it. The bench numbers the cycles of a transaction from the first cycle after the edge that captured `run`. It then expects level changes at multiples of D·S·T, and strobes at D·floor(S·T/2) into each high half. After a `mcode_done` pulse in cycle k, counting restarts at cycle k+1 with the new product and the SCL level held. After `run` falls, the idle state is due in the very next cycle. The bench drives inputs and compares every output on the falling clock edge, once per cycle, against these formulas.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    // Timing word layout and counter widths
    localparam int WORD_W      = 16;
    localparam int SMP_W       = 3;
    localparam int STP_W       = 6;
    localparam int HS_STP_W    = 3;
    localparam int STD_SMP_LSB = 8;
    localparam int STD_STP_LSB = 0;
    localparam int HS_SMP_LSB  = 12;
    localparam int HS_STP_LSB  = 8;
    localparam int HS_EN_LSB   = 0;
    localparam int HS_EN_W     = 2;
    // position counter must hold S*T - 1 (max 511) and the product itself
    localparam int CNT_W       = SMP_W + STP_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STD   = 2'd1,
        PH_MCODE = 2'd2,
        PH_HS    = 2'd3
    } ssg_phase_e;

    typedef struct packed {
        logic [SMP_W-1:0] smp_m1;
        logic [STP_W-1:0] stp_m1;
    } ssg_lim_t;

    // Number of predivided ticks before the sample strobe in a high half
    function automatic logic [CNT_W-1:0] half_mid(input ssg_lim_t lim);
        logic [CNT_W-1:0] s;
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] p;
        s = CNT_W'(lim.smp_m1) + CNT_W'(1);
        t = CNT_W'(lim.stp_m1) + CNT_W'(1);
        p = s * t;
        return p >> 1;
    endfunction

endpackage

// File: rtl/ssg_prediv.sv
module ssg_prediv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign tick = en && !clr && (st_q.cnt == lim);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (en) begin
            if (tick) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (st_q.cnt <= lim));

    // R2
    tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));

endmodule

// File: rtl/ssg_nest.sv
module ssg_nest
    import ssg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  ssg_lim_t         lim,
    input  logic [CNT_W-1:0] mid_nxt,
    output logic             half_end,
    output logic             mid_hit
);

    typedef struct packed {
        logic [STP_W-1:0] stp;
        logic [SMP_W-1:0] smp;
        logic [CNT_W-1:0] pos;
    } st_t;

    st_t  st_d, st_q;
    logic stp_wrap;
    logic smp_wrap;
    logic fresh;

    assign stp_wrap = (st_q.stp == lim.stp_m1);
    assign smp_wrap = (st_q.smp == lim.smp_m1);
    assign half_end = tick && !clr && stp_wrap && smp_wrap;

    always_comb begin
        st_d  = st_q;
        fresh = 1'b0;
        if (clr) begin
            st_d  = '0;
            fresh = 1'b1;
        end else if (tick) begin
            fresh = 1'b1;
            if (half_end) begin
                st_d = '0;
            end else begin
                st_d.pos = st_q.pos + CNT_W'(1);
                if (stp_wrap) begin
                    st_d.stp = '0;
                    st_d.smp = st_q.smp + SMP_W'(1);
                end else begin
                    st_d.stp = st_q.stp + STP_W'(1);
                end
            end
        end
        mid_hit = fresh && (st_d.pos == mid_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    counters_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (st_q.stp <= lim.stp_m1 && st_q.smp <= lim.smp_m1));

    // R3
    pos_tracks_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |-> (st_q.pos ==
            CNT_W'(st_q.smp) * (CNT_W'(lim.stp_m1) + CNT_W'(1)) + CNT_W'(st_q.stp)));

endmodule

// File: rtl/ssg_scl_timing.sv
module ssg_scl_timing
    import ssg_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mcode_done,
    input  logic [DIV_W-1:0]  div_m1,
    input  logic [WORD_W-1:0] std_word,
    input  logic [WORD_W-1:0] hs_word,
    output logic              scl_o,
    output logic              half_tick_o,
    output logic              sample_stb_o,
    output logic              hs_active_o
);

    typedef struct packed {
        logic             active;
        ssg_phase_e       phase;
        logic [DIV_W-1:0] div_m1;
        ssg_lim_t         std_lim;
        ssg_lim_t         hs_lim;
        logic             hs_en;
        logic             scl;
        logic             half;
        logic             stb;
    } st_t;

    localparam st_t RST_ST = '{
        active:  1'b0,
        phase:   PH_IDLE,
        div_m1:  '0,
        std_lim: '0,
        hs_lim:  '0,
        hs_en:   1'b0,
        scl:     1'b1,
        half:    1'b0,
        stb:     1'b0
    };

    st_t st_d, st_q;

    // Field extraction from the input words
    ssg_lim_t std_in;
    ssg_lim_t hs_in;
    logic     hs_en_in;
    logic     unused_bits;

    assign std_in.smp_m1 = std_word[STD_SMP_LSB +: SMP_W];
    assign std_in.stp_m1 = std_word[STD_STP_LSB +: STP_W];
    assign hs_in.smp_m1  = hs_word[HS_SMP_LSB +: SMP_W];
    assign hs_in.stp_m1  = STP_W'(hs_word[HS_STP_LSB +: HS_STP_W]);
    assign hs_en_in      = (hs_word[HS_EN_LSB +: HS_EN_W] == 2'b11);
    assign unused_bits   = ^{std_word[15:11], std_word[7:6], hs_word[15],
                             hs_word[11], hs_word[7:2]};

    // Transaction control events
    logic     load;
    logic     sw;
    logic     cnt_clr;
    logic     cnt_en;
    ssg_lim_t cur_lim;
    ssg_lim_t nxt_lim;
    logic     [CNT_W-1:0] mid_nxt;
    logic     div_tick;
    logic     half_end;
    logic     mid_hit;

    assign load    = !st_q.active && run;
    assign sw      = st_q.active && run && (st_q.phase == PH_MCODE) && mcode_done;
    assign cnt_clr = !st_q.active || !run || sw;
    assign cnt_en  = st_q.active && run;
    assign cur_lim = (st_q.phase == PH_HS) ? st_q.hs_lim : st_q.std_lim;
    assign nxt_lim = load ? std_in : (sw ? st_q.hs_lim : cur_lim);
    assign mid_nxt = half_mid(nxt_lim);

    ssg_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .lim   (st_q.div_m1),
        .tick  (div_tick)
    );

    ssg_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .tick     (div_tick),
        .lim      (cur_lim),
        .mid_nxt  (mid_nxt),
        .half_end (half_end),
        .mid_hit  (mid_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.half = 1'b0;
        if (!st_q.active) begin
            if (run) begin
                st_d.active  = 1'b1;
                st_d.phase   = hs_en_in ? PH_MCODE : PH_STD;
                st_d.div_m1  = div_m1;
                st_d.std_lim = std_in;
                st_d.hs_lim  = hs_in;
                st_d.hs_en   = hs_en_in;
                st_d.scl     = 1'b1;
            end
        end else if (!run) begin
            st_d.active = 1'b0;
            st_d.phase  = PH_IDLE;
            st_d.scl    = 1'b1;
        end else if (sw) begin
            st_d.phase = PH_HS;
        end else if (half_end) begin
            st_d.scl  = !st_q.scl;
            st_d.half = 1'b1;
        end
        st_d.stb = st_d.active && st_d.scl && mid_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign scl_o        = st_q.scl;
    assign half_tick_o  = st_q.half;
    assign sample_stb_o = st_q.stb;
    assign hs_active_o  = (st_q.phase == PH_HS);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (scl_o && !half_tick_o && !sample_stb_o && !hs_active_o));

    // R4
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && run && !half_end) |=> $stable(st_q.scl));

    // R4
    half_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick_o |-> (scl_o != $past(scl_o)));

    // R5
    stb_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> scl_o);

    // R6
    hs_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active_o |-> st_q.hs_en);

    // R7
    hs_after_mcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active_o) |-> $past(mcode_done));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && run) |=> ($stable(st_q.div_m1) && $stable(st_q.std_lim)
                                  && $stable(st_q.hs_lim) && $stable(st_q.hs_en)));

endmodule

// File: tb/tb_ssg_scl_timing.sv
`timescale 1ns/1ps
module tb_ssg_scl_timing;

    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic             mcode_done = 1'b0;
    logic [DIV_W-1:0] div_m1 = '0;
    logic [15:0]      std_word = '0;
    logic [15:0]      hs_word = '0;
    logic             scl, half, stb, hs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ssg_scl_timing #(.DIV_W(DIV_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .mcode_done   (mcode_done),
        .div_m1       (div_m1),
        .std_word     (std_word),
        .hs_word      (hs_word),
        .scl_o        (scl),
        .half_tick_o  (half),
        .sample_stb_o (stb),
        .hs_active_o  (hs)
    );

    // R3 layout: S-1 in [10:8], T-1 in [5:0]
    function automatic logic [15:0] mk_std(input int smp_m1, input int stp_m1);
        logic [15:0] w = '0;
        w[10:8] = smp_m1[2:0];
        w[5:0]  = stp_m1[5:0];
        return w;
    endfunction

    // R6 layout: S-1 in [14:12], T-1 in [10:8], enable code in [1:0]
    function automatic logic [15:0] mk_hs(input int smp_m1, input int stp_m1, input logic [1:0] en);
        logic [15:0] w = '0;
        w[14:12] = smp_m1[2:0];
        w[10:8]  = stp_m1[2:0];
        w[1:0]   = en;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check({scl, half, stb, hs} == 4'b1000, req, "idle {scl,half,stb,hs}",
              int'({scl, half, stb, hs}), 8);
    endtask

    // At the falling edge of cycle c0 (not yet checked); compares n cycles.
    task automatic observe(input bit lvl0, input int d, input int n_st, input int mid,
                           input int c0, input int n, input bit exp_hs, input string req);
        int hl = d * n_st;
        int e_scl = 0, e_half = 0, e_stb = 0, e_hs = 0;
        int a_scl = 0, x_scl = 0, a_half = 0, x_half = 0;
        int a_stb = 0, x_stb = 0, a_hs = 0, x_hs = 0;
        for (int c = c0; c < c0 + n; c++) begin
            bit l  = lvl0 ^ bit'((c / hl) % 2);
            bit eh = (c > 0) && (c % hl == 0);
            bit es = l && (c % hl == mid * d);
            if (scl != l)      begin if (e_scl == 0)  begin a_scl = scl;  x_scl = l;      end e_scl++;  end
            if (half != eh)    begin if (e_half == 0) begin a_half = half; x_half = eh;   end e_half++; end
            if (stb != es)     begin if (e_stb == 0)  begin a_stb = stb;  x_stb = es;     end e_stb++;  end
            if (hs != exp_hs)  begin if (e_hs == 0)   begin a_hs = hs;    x_hs = exp_hs;  end e_hs++;   end
            @(negedge clk);
        end
        check(e_scl == 0,  req, "scl level per cycle", a_scl, x_scl);
        check(e_half == 0, {req, " R4"}, "half tick per cycle", a_half, x_half);
        check(e_stb == 0,  {req, " R5"}, "sample strobe per cycle", a_stb, x_stb);
        check(e_hs == 0,   {req, " R6"}, "hs_active per cycle", a_hs, x_hs);
    endtask

    task automatic start_txn(input int dm1, input logic [15:0] sw, input logic [15:0] hw);
        div_m1   = dm1[DIV_W-1:0];
        std_word = sw;
        hs_word  = hw;
        run      = 1'b1;
        @(negedge clk);
    endtask

    // R10: idle one cycle after run falls, and stays idle
    task automatic end_txn();
        run = 1'b0;
        @(negedge clk);
        check_idle("R10");
        repeat (2) @(negedge clk);
        check_idle("R10");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
    endtask

    // R1: inputs move while run is low
    task automatic t_idle_inputs();
        for (int i = 0; i < 8; i++) begin
            div_m1     = DIV_W'(i);
            std_word   = mk_std(i % 8, i);
            hs_word    = mk_hs(i % 8, i % 8, 2'b11);
            mcode_done = i[0];
            @(negedge clk);
            check_idle("R1 idle with moving inputs");
        end
        mcode_done = 1'b0;
    endtask

    // R2 R3: standard timing only
    task automatic t_std(input int dm1, input int smp_m1, input int stp_m1,
                         input int halves, input string req);
        int d = dm1 + 1;
        int n_st = (smp_m1 + 1) * (stp_m1 + 1);
        start_txn(dm1, mk_std(smp_m1, stp_m1) | 16'h38C0, 16'h0000);
        observe(1'b1, d, n_st, n_st / 2, 0, halves * n_st * d + 1, 1'b0, req);
        end_txn();
    endtask

    // R9: changes during a transaction ignored, taken at the next start
    task automatic t_midchange();
        start_txn(2, mk_std(0, 4), 16'h0000);
        observe(1'b1, 3, 5, 2, 0, 21, 1'b0, "R9 before change");
        div_m1   = '0;
        std_word = mk_std(7, 0);
        hs_word  = mk_hs(7, 7, 2'b11);
        observe(1'b1, 3, 5, 2, 21, 40, 1'b0, "R9 after change");
        end_txn();
        run = 1'b1;
        @(negedge clk);
        observe(1'b1, 1, 8, 4, 0, 40, 1'b0, "R9 new values at next start");
        end_txn();
    endtask

    // R7 R8: master-code phase then high-speed phase
    task automatic t_hs();
        start_txn(3, mk_std(1, 2), mk_hs(0, 1, 2'b11));
        observe(1'b1, 4, 6, 3, 0, 30, 1'b0, "R7 master-code phase");
        mcode_done = 1'b1;
        observe(1'b1, 4, 6, 3, 30, 1, 1'b0, "R7 switch cycle");
        mcode_done = 1'b0;
        observe(1'b0, 4, 2, 1, 0, 40, 1'b1, "R7 high-speed phase");
        mcode_done = 1'b1;
        observe(1'b0, 4, 2, 1, 40, 1, 1'b1, "R8 repeat pulse");
        mcode_done = 1'b0;
        observe(1'b0, 4, 2, 1, 41, 30, 1'b1, "R8 after repeat pulse");
        end_txn();
    endtask

    // R6 R8: enable code not 2'b11 -> mcode_done ignored
    task automatic t_hs_off();
        start_txn(1, mk_std(1, 1), mk_hs(0, 1, 2'b10));
        observe(1'b1, 2, 4, 2, 0, 20, 1'b0, "R6 disabled word");
        mcode_done = 1'b1;
        observe(1'b1, 2, 4, 2, 20, 1, 1'b0, "R8 ignored pulse");
        mcode_done = 1'b0;
        observe(1'b1, 2, 4, 2, 21, 20, 1'b0, "R8 after ignored pulse");
        end_txn();
    endtask

    initial begin
        t_reset();
        t_idle_inputs();
        @(negedge clk);
        t_std(4, 2, 3, 4, "R2 R3 default divide-by-5");
        t_std(0, 0, 0, 8, "R3 R5 minimum counts");
        t_std(2, 2, 4, 4, "R3 R5 odd product");
        t_std(15, 0, 1, 4, "R2 largest divisor");
        t_std(1, 7, 63, 2, "R3 largest counts");
        t_midchange();
        t_hs();
        t_hs_off();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule